// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block sits directly behind clock recovery on a SONET/SDH receive path. It takes the recovered serial bit stream one bit per bit-clock cycle, most significant bit of each byte first. It hunts at every bit position for the framing word. That word is three A1 bytes (0xF6) followed with no gap by three A2 bytes (0x28). Both the frame start and the byte boundary come from the first full 48-bit match. Matching a single framing byte, or a partial run, is never enough.

Once locked, the block assembles each group of eight bits on the fixed grid into a parallel byte. It publishes the byte with a one-cycle valid strobe and holds the byte until the next strobe. The first byte after the framing word also carries a frame-sync flag for one byte period. The search is then frozen, and the grid does not move, until an out-of-frame request drops the block back into hunting.

Everything runs in the bit clock domain. At 155.52 or 622.08 Mb/s line rate the byte strobe ticks at 19.44 or 77.76 MHz.

Top module: `sonet_frame_aligner`

## Requirements
- R1: While and after synchronous reset, `byte_o` is 0x00, `byte_vld_o` is 0 and `fsync_o` is 0.
- R2: Lock is acquired whatever the bit offset of the framing word relative to any earlier bit. The framing word is 0xF6,0xF6,0xF6,0x28,0x28,0x28, received MSB first.
- R3: Incomplete framing runs never produce lock or any byte strobe. Examples are two A1 with three A2, three A1 with two A2, and a corrupted byte between the A2 bytes.
- R4: The clock edge that samples the last framing bit is edge L. `byte_vld_o` is then high for exactly one cycle after edge L+8k for every k ≥ 1, and low after every other edge.
- R5: The byte published after edge L+8k holds the bits sampled at edges L+8k-7 through L+8k. The earliest of these bits is in bit 7 and the latest in bit 0.
- R6: `fsync_o` is high after edges L+8 through L+15, which is the byte period of the first byte after the framing word. It is low at all other times.
- R7: While locked, the strobe grid stays fixed. A second framing word at a different offset moves neither the strobes nor `fsync_o`.
- R8: When `oof_i` is sampled high, `byte_vld_o` and `fsync_o` are 0 after that edge. The hunt then restarts and can lock at a new offset.
- R9: While unaligned, `byte_vld_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sdata_i | input | 1 | Serial data bit, MSB of each byte first |
| oof_i | input | 1 | Out-of-frame request; drops lock and restarts the hunt |
| byte_o | output | 8 | Aligned byte, held between strobes |
| byte_vld_o | output | 1 | One-cycle strobe marking a new byte on `byte_o` |
| fsync_o | output | 1 | High for the byte period of the first byte after the framing word |

## Verification
The bench sweeps the framing word across sixteen preamble lengths, so every bit offset appears at least twice. A design that compared only on byte boundaries would miss most of these offsets. An off-by-one in the bit counter would shift every strobe and rotate every byte. Truncated framing runs are fed to catch a detector that matches a shorter window. A second framing word placed off-grid while locked exposes a design that keeps searching, because it would re-slip the grid or repeat the frame pulse. Out-of-frame requests in mid-payload and between scenarios check that outputs stop at once and that the next lock takes up the new offset.

// File: rtl/sonet_align_pkg.sv
package sonet_align_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } align_st_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              vld;
        logic              fsync;
    } byte_out_t;

    function automatic logic [CNT_W-1:0] last_bit_idx();
        return CNT_W'(BYTE_W - 1);
    endfunction

endpackage

// File: rtl/sfa_pattern_detector.sv
module sfa_pattern_detector
    import sonet_align_pkg::*;
#(
    parameter int unsigned     A1_CNT  = 3,
    parameter int unsigned     A2_CNT  = 3,
    parameter logic [BYTE_W-1:0] A1_CODE = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_CODE = 8'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdata_i,
    output logic              hit_o,
    output logic [BYTE_W-1:0] window_o
);
    localparam int unsigned NBYTES = A1_CNT + A2_CNT;
    localparam int unsigned PAT_W  = NBYTES * BYTE_W;

    logic [PAT_W-1:0] shreg;
    logic [PAT_W-1:0] pattern;

    for (genvar g = 0; g < NBYTES; g++) begin : g_pat
        if (g < A1_CNT) begin : g_a1
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A1_CODE;
        end else begin : g_a2
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A2_CODE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[PAT_W-2:0], sdata_i};
        end
    end

    assign hit_o    = (shreg == pattern);
    assign window_o = {shreg[BYTE_W-2:0], sdata_i};

endmodule

// File: rtl/sfa_align_ctrl.sv
module sfa_align_ctrl
    import sonet_align_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic oof_i,
    output logic locked_o,
    output logic tick_o,
    output logic first_o
);
    align_st_e        st;
    logic [CNT_W-1:0] bitcnt;
    logic             first_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_HUNT;
            bitcnt     <= '0;
            first_pend <= 1'b0;
        end else if (oof_i) begin
            st         <= ST_HUNT;
            first_pend <= 1'b0;
        end else begin
            case (st)
                ST_HUNT: begin
                    if (hit_i) begin
                        st         <= ST_LOCK;
                        bitcnt     <= CNT_W'(1);
                        first_pend <= 1'b1;
                    end
                end
                default: begin
                    bitcnt <= bitcnt + CNT_W'(1);
                    if (tick_o) begin
                        first_pend <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign locked_o = (st == ST_LOCK);
    assign tick_o   = locked_o && !oof_i && (bitcnt == last_bit_idx());
    assign first_o  = first_pend;

    AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (!locked_o && hit_i && !oof_i) |=> locked_o); // R2
    AST_OOF_REARM: assert property (@(posedge clk) disable iff (rst)
        oof_i |=> !locked_o); // R8
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !oof_i) |=> locked_o); // R7

endmodule

// File: rtl/sfa_byte_out.sv
module sfa_byte_out
    import sonet_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              locked_i,
    input  logic              oof_i,
    input  logic              tick_i,
    input  logic              first_i,
    input  logic [BYTE_W-1:0] window_i,
    output byte_out_t         out_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else if (oof_i || !locked_i) begin
            out_o.vld   <= 1'b0;
            out_o.fsync <= 1'b0;
        end else if (tick_i) begin
            out_o.data  <= window_i;
            out_o.vld   <= 1'b1;
            out_o.fsync <= first_i;
        end else begin
            out_o.vld <= 1'b0;
        end
    end

    AST_VLD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        !locked_i |=> !out_o.vld); // R9
    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_o.vld |=> !out_o.vld); // R4
    AST_FSYNC_STARTS_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_o.fsync) |-> out_o.vld); // R6
    AST_OOF_SILENCES: assert property (@(posedge clk) disable iff (rst)
        oof_i |=> (!out_o.vld && !out_o.fsync)); // R8

endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner
    import sonet_align_pkg::*;
#(
    parameter int unsigned     A1_CNT  = 3,
    parameter int unsigned     A2_CNT  = 3,
    parameter logic [BYTE_W-1:0] A1_CODE = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_CODE = 8'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdata_i,
    input  logic              oof_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              fsync_o
);
    logic              hit;
    logic [BYTE_W-1:0] window;
    logic              locked;
    logic              tick;
    logic              first;
    byte_out_t         bout;

    sfa_pattern_detector #(
        .A1_CNT (A1_CNT),
        .A2_CNT (A2_CNT),
        .A1_CODE(A1_CODE),
        .A2_CODE(A2_CODE)
    ) i_det (
        .clk     (clk),
        .rst     (rst),
        .sdata_i (sdata_i),
        .hit_o   (hit),
        .window_o(window)
    );

    sfa_align_ctrl i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit),
        .oof_i   (oof_i),
        .locked_o(locked),
        .tick_o  (tick),
        .first_o (first)
    );

    sfa_byte_out i_out (
        .clk     (clk),
        .rst     (rst),
        .locked_i(locked),
        .oof_i   (oof_i),
        .tick_i  (tick),
        .first_i (first),
        .window_i(window),
        .out_o   (bout)
    );

    assign byte_o     = bout.data;
    assign byte_vld_o = bout.vld;
    assign fsync_o    = bout.fsync;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!byte_vld_o && !fsync_o && byte_o == '0)); // R1

endmodule

// File: tb/test_sonet_frame_aligner.sv
module test_sonet_frame_aligner;

    logic       clk = 1'b0;
    logic       rst;
    logic       sdata_i;
    logic       oof_i;
    logic [7:0] byte_o;
    logic       byte_vld_o;
    logic       fsync_o;

    int nvec  = 0;
    int nerr  = 0;
    bit done  = 0;

    logic sbits [0:2047];
    int   nbits;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    sonet_frame_aligner i_sonet_frame_aligner (
        .clk       (clk),
        .rst       (rst),
        .sdata_i   (sdata_i),
        .oof_i     (oof_i),
        .byte_o    (byte_o),
        .byte_vld_o(byte_vld_o),
        .fsync_o   (fsync_o)
    );

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        nvec++;
        if (act != exp_v) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            sbits[nbits] = b[k];
            nbits++;
        end
    endtask

    task automatic push_noise(input int n);
        for (int k = 0; k < n; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sbits[nbits] = lfsr[0];
            nbits++;
        end
    endtask

    task automatic push_flush();
        for (int k = 0; k < 8; k++) begin
            sbits[nbits] = 1'b0;
            nbits++;
        end
    endtask

    task automatic push_pattern(output int last);
        for (int k = 0; k < 3; k++) push_byte(8'hF6);
        for (int k = 0; k < 3; k++) push_byte(8'h28);
        last = nbits - 1;
    endtask

    task automatic push_payload(input int n, input int seed);
        for (int k = 0; k < n; k++) push_byte(8'((k * 37 + seed * 11 + 5) & 8'hFF));
    endtask

    task automatic do_oof();
        @(negedge clk);
        sdata_i = 1'b0;
        oof_i   = 1'b1;
        @(posedge clk);
        #2;
        chk("R8", int'(byte_vld_o), 0, "vld after oof");
        chk("R8", int'(fsync_o), 0, "fsync after oof");
        @(negedge clk);
        oof_i = 1'b0;
    endtask

    // Drive sbits[0..nbits-1]; L = index of last framing bit (-1: no lock expected)
    task automatic run(input int last, input int oof_at, input string tag);
        for (int i = 0; i < nbits; i++) begin
            logic       ev, ef;
            logic [7:0] eb;
            int         d;
            @(negedge clk);
            sdata_i = sbits[i];
            oof_i   = (i == oof_at);
            @(posedge clk);
            #2;
            ev = 1'b0;
            ef = 1'b0;
            eb = '0;
            if (!(oof_at >= 0 && i >= oof_at) && last >= 0 && i > last) begin
                d  = i - last;
                ev = ((d % 8) == 0);
                ef = (d >= 8) && (d < 16);
                if (ev) begin
                    for (int k = 0; k < 8; k++) eb[7-k] = sbits[i-7+k];
                end
            end
            chk(tag, int'(byte_vld_o), int'(ev), "byte_vld_o (R4)");
            chk(tag, int'(fsync_o), int'(ef), "fsync_o (R6)");
            if (ev) chk(tag, int'(byte_o), int'(eb), "byte_o (R5)");
        end
        @(negedge clk);
        oof_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int last;
        rst     = 1'b1;
        sdata_i = 1'b1;
        oof_i   = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", int'(byte_o), 0, "byte_o in reset");
        chk("R1", int'(byte_vld_o), 0, "vld in reset");
        chk("R1", int'(fsync_o), 0, "fsync in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk("R1", int'(byte_vld_o), 0, "vld after reset");

        // R2 / R4 / R5 / R6: framing word at every bit offset
        for (int pre = 0; pre < 16; pre++) begin
            do_oof();
            nbits = 0;
            push_flush();
            push_noise(pre);
            push_pattern(last);
            push_payload(6, pre);
            run(last, -1, "R2");
        end

        // R3 / R9: truncated or corrupted framing runs
        do_oof();
        nbits = 0;
        push_flush();
        for (int k = 0; k < 3; k++) push_byte(8'hF6);
        for (int k = 0; k < 2; k++) push_byte(8'h28);
        push_payload(4, 1);
        run(-1, -1, "R3");

        nbits = 0;
        push_flush();
        for (int k = 0; k < 2; k++) push_byte(8'hF6);
        for (int k = 0; k < 3; k++) push_byte(8'h28);
        push_payload(4, 2);
        run(-1, -1, "R3");

        nbits = 0;
        push_flush();
        push_noise(3);
        for (int k = 0; k < 3; k++) push_byte(8'hF6);
        push_byte(8'h28);
        push_byte(8'h29);
        push_byte(8'h28);
        push_payload(4, 3);
        run(-1, -1, "R9");

        // R7: second framing word off-grid while locked
        nbits = 0;
        push_flush();
        push_noise(5);
        push_pattern(last);
        push_payload(2, 4);
        push_noise(3);
        begin
            int dummy;
            push_pattern(dummy);
        end
        push_payload(5, 5);
        run(last, -1, "R7");

        // R8: out-of-frame in mid payload, then relock at a new offset
        do_oof();
        nbits = 0;
        push_flush();
        push_noise(2);
        push_pattern(last);
        push_payload(6, 6);
        run(last, last + 21, "R8");

        nbits = 0;
        push_flush();
        push_noise(7);
        push_pattern(last);
        push_payload(5, 7);
        run(last, -1, "R8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule